// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block merges command-completion events from several storage ports into one
level interrupt. Each port raises a one-cycle completion pulse; several ports may
pulse in the same cycle. The block adds up the completions and holds the
interrupt back until either the running total reaches a programmable count, or
a programmable number of core clocks has passed since the first completion of
the current batch. Whichever condition is met first latches a cause bit.
Software clears that bit by writing a one to it.

The time threshold is counted in core clocks. With a 150 MHz core the driver
writes microseconds times 150. A time threshold of zero switches coalescing off.
In that state completions are not counted, no event is raised, and the coalesced
interrupt is masked. Thresholds reset to zero, so the block starts switched off.

Top module: `cmpl_irq_coalescer`

## Requirements
- R1: After reset the cause vector reads all zeros, `irq_o` is low and both thresholds are zero.
- R2: While the time threshold is zero, completions are neither counted nor timed and raise no event. Any pending count and any running timer are dropped. `irq_o` stays low even when the cause bit is set.
- R3: With a nonzero time threshold, each cycle adds the number of set bits in `done_pulse`. The event fires at the clock edge where the running total reaches the count threshold, and the cause bit reads 1 from that edge on.
- R4: A count threshold of 0 or 1 with a nonzero time threshold makes every cycle that has a completion fire at once.
- R5: The timer starts on the edge that captures the first completion of a batch. Later completions do not restart it. The event fires on the T-th edge after that, where T is the time threshold, unless the count fires first.
- R6: An event clears both the pending count and the timer. Completions in the firing cycle are covered by that event and do not carry into the next batch.
- R7: The cause vector is 8 bits wide and only bit 4 is implemented; the other bits read 0. A clear write with bit 4 = 1 clears it. A clear write with bit 4 = 0 has no effect.
- R8: When an event and a clear of bit 4 fall in the same cycle, the bit ends up set.
- R9: Completions that arrive while the cause bit is set keep counting toward the next event.
- R10: `irq_o` is high exactly when cause bit 4 is set, `irq_en` is high and the time threshold is nonzero.
- R11: Threshold writes take effect from the cycle after the write. The count threshold is 8 bits (up to 255) and the time threshold is 24 bits (up to 2^24-1 clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_pulse | input | NUM_PORTS | One-cycle completion pulse per port |
| cnt_thr_we | input | 1 | Write strobe for the count threshold |
| cnt_thr_wdata | input | CNT_W | Count threshold value |
| time_thr_we | input | 1 | Write strobe for the time threshold |
| time_thr_wdata | input | TIME_W | Time threshold in core clocks |
| cause_clr_we | input | 1 | Write strobe for the write-one-to-clear cause register |
| cause_clr_data | input | CAUSE_W | Bits written as one are cleared |
| irq_en | input | 1 | Interrupt enable |
| cause_q | output | CAUSE_W | Cause vector; bit 4 is the coalescing event |
| irq_o | output | 1 | Level interrupt |

## Verification
Two functions can land in the same clock cycle: a new event setting the cause bit, and software clearing it. A second such pair is the timeout and a completion arriving on that same edge. The bench drives a completion together with a clear write under a count threshold of one, and requires the bit to stay set. It also places a pulse exactly on the timeout edge and then requires that no event appears in the quiet cycles that follow, which shows that the completion was absorbed. Around these cases the bench sweeps the count threshold against the number of ports pulsing together, and the time threshold against the edge on which the bit rises. The expected edge is computed as a rounded-up quotient or as a plain offset.

// File: rtl/coal_pkg.sv
package coal_pkg;
   localparam int unsigned COAL_CAUSE_W   = 8;
   localparam int unsigned COAL_CAUSE_BIT = 4;

   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_COUNT = 2'd1,
      SRC_TIME  = 2'd2
   } fire_src_e;

   function automatic logic [COAL_CAUSE_W-1:0] bit_mask(input int unsigned pos);
      logic [COAL_CAUSE_W-1:0] m;
      m = '0;
      m[pos] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/coal_popcount.sv
module coal_popcount #(
   parameter int unsigned N    = 4,
   parameter int unsigned OUTW = 3
) (
   input  logic [N-1:0]    vec,
   output logic [OUTW-1:0] count
);
   generate
      if (N == 1) begin : g_single
         assign count = OUTW'(vec[0]);
      end else begin : g_multi
         always_comb begin
            count = '0;
            for (int i = 0; i < N; i++) begin
               count = count + OUTW'(vec[i]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/coal_event_counter.sv
module coal_event_counter #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned ADD_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [ADD_W-1:0] add,
   input  logic [CNT_W-1:0] thr,
   input  logic             fire,
   output logic             hit,
   output logic [CNT_W-1:0] pend_q
);
   localparam int unsigned SUM_W = CNT_W + 1;

   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] eff_thr;

   assign sum     = {1'b0, pend_q} + SUM_W'(add);
   assign eff_thr = (thr == '0) ? SUM_W'(1) : {1'b0, thr};
   assign hit     = enable && (add != '0) && (sum >= eff_thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (!enable || fire) begin
         pend_q <= '0;
      end else begin
         pend_q <= sum[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/coal_timer.sv
module coal_timer #(
   parameter int unsigned TIME_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              start,
   input  logic [TIME_W-1:0] thr,
   input  logic              fire,
   output logic              expire,
   output logic              run_q
);
   logic [TIME_W-1:0] tmr_q;

   assign expire = enable && run_q && (tmr_q >= thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         tmr_q <= '0;
      end else if (!enable || fire) begin
         run_q <= 1'b0;
         tmr_q <= '0;
      end else if (run_q) begin
         tmr_q <= tmr_q + 1'b1;
      end else if (start) begin
         run_q <= 1'b1;
         tmr_q <= TIME_W'(1);
      end
   end
endmodule

// File: rtl/coal_cause_reg.sv
module coal_cause_reg #(
   parameter int unsigned W   = 8,
   parameter int unsigned POS = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set,
   input  logic         clr_we,
   input  logic [W-1:0] clr_data,
   output logic [W-1:0] cause_q
);
   localparam logic [W-1:0] IMPL = W'(1) << POS;

   logic [W-1:0] set_vec;
   logic [W-1:0] clr_vec;

   assign set_vec = set ? IMPL : '0;
   assign clr_vec = clr_we ? clr_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
      end else begin
         cause_q <= ((cause_q & ~clr_vec) | set_vec) & IMPL;
      end
   end
endmodule

// File: rtl/cmpl_irq_coalescer.sv
module cmpl_irq_coalescer #(
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned TIME_W    = 24,
   parameter int unsigned CAUSE_W   = coal_pkg::COAL_CAUSE_W,
   parameter int unsigned CAUSE_BIT = coal_pkg::COAL_CAUSE_BIT
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] done_pulse,
   input  logic                 cnt_thr_we,
   input  logic [CNT_W-1:0]     cnt_thr_wdata,
   input  logic                 time_thr_we,
   input  logic [TIME_W-1:0]    time_thr_wdata,
   input  logic                 cause_clr_we,
   input  logic [CAUSE_W-1:0]   cause_clr_data,
   input  logic                 irq_en,
   output logic [CAUSE_W-1:0]   cause_q,
   output logic                 irq_o
);
   import coal_pkg::*;

   localparam int unsigned PC_W = $clog2(NUM_PORTS + 1);

   generate
      if (NUM_PORTS < 1) begin : g_chk_ports
         $error("NUM_PORTS must be at least 1");
      end
      if (PC_W > CNT_W) begin : g_chk_cnt
         $error("CNT_W too narrow for NUM_PORTS");
      end
      if (CAUSE_BIT >= CAUSE_W) begin : g_chk_bit
         $error("CAUSE_BIT outside cause vector");
      end
      if (TIME_W < 2) begin : g_chk_time
         $error("TIME_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_thr_q;
   logic [TIME_W-1:0] time_thr_q;
   logic              coal_on;
   logic [PC_W-1:0]   n_done;
   logic              hit;
   logic              expire;
   logic              fire;
   logic [CNT_W-1:0]  pend_q;
   logic              tmr_run;
   fire_src_e         fire_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_thr_q  <= '0;
         time_thr_q <= '0;
      end else begin
         if (cnt_thr_we)  cnt_thr_q  <= cnt_thr_wdata;
         if (time_thr_we) time_thr_q <= time_thr_wdata;
      end
   end

   assign coal_on = (time_thr_q != '0);

   coal_popcount #(.N(NUM_PORTS), .OUTW(PC_W)) u_pop (
      .vec   (done_pulse),
      .count (n_done)
   );

   coal_event_counter #(.CNT_W(CNT_W), .ADD_W(PC_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (coal_on),
      .add    (n_done),
      .thr    (cnt_thr_q),
      .fire   (fire),
      .hit    (hit),
      .pend_q (pend_q)
   );

   coal_timer #(.TIME_W(TIME_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (coal_on),
      .start  (n_done != '0),
      .thr    (time_thr_q),
      .fire   (fire),
      .expire (expire),
      .run_q  (tmr_run)
   );

   always_comb begin
      if (hit)         fire_src = SRC_COUNT;
      else if (expire) fire_src = SRC_TIME;
      else             fire_src = SRC_NONE;
   end

   assign fire = (fire_src != SRC_NONE);

   coal_cause_reg #(.W(CAUSE_W), .POS(CAUSE_BIT)) u_cause (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (fire),
      .clr_we   (cause_clr_we),
      .clr_data (cause_clr_data),
      .cause_q  (cause_q)
   );

   assign irq_o = cause_q[CAUSE_BIT] & irq_en & coal_on;
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned TIME_W    = 24,
   parameter int unsigned CAUSE_W   = 8,
   parameter int unsigned CAUSE_BIT = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               fire,
   input logic               tmr_run,
   input logic               irq_en,
   input logic               irq_o,
   input logic               clr_we,
   input logic [CAUSE_W-1:0] clr_data,
   input logic [CAUSE_W-1:0] cause_q,
   input logic [CNT_W-1:0]   pend_q,
   input logic [TIME_W-1:0]  time_thr_q
);
   logic clr_hit;
   assign clr_hit = clr_we && clr_data[CAUSE_BIT];

   // R3 R5: an event always leaves the cause bit set
   assert_fire_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> cause_q[CAUSE_BIT]);

   // R8: set wins over a simultaneous clear
   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && clr_hit) |=> cause_q[CAUSE_BIT]);

   // R7: a clear without an event empties the bit
   assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !fire) |=> !cause_q[CAUSE_BIT]);

   // R7: without event or clear the bit holds
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire && !clr_hit) |=> $stable(cause_q[CAUSE_BIT]));

   // R7: unimplemented bits read zero
   assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cause_q) <= 1 && (cause_q[CAUSE_BIT] || cause_q == '0));

   // R2: switched off, nothing is pending or timed
   assert_off_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (time_thr_q == '0) |=> (pend_q == '0 && !tmr_run));

   // R6: an event clears the pending count and the timer
   assert_fire_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (pend_q == '0 && !tmr_run));

   // R10: the interrupt needs the cause bit, the enable and a nonzero time threshold
   assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (cause_q[CAUSE_BIT] && irq_en && time_thr_q != '0));
endmodule

bind cmpl_irq_coalescer coal_checker #(
   .CNT_W(CNT_W), .TIME_W(TIME_W), .CAUSE_W(CAUSE_W), .CAUSE_BIT(CAUSE_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fire       (fire),
   .tmr_run    (tmr_run),
   .irq_en     (irq_en),
   .irq_o      (irq_o),
   .clr_we     (cause_clr_we),
   .clr_data   (cause_clr_data),
   .cause_q    (cause_q),
   .pend_q     (pend_q),
   .time_thr_q (time_thr_q)
);

// File: tb/cmpl_irq_coalescer_test.sv
`timescale 1ns/1ps
module cmpl_irq_coalescer_test;
   localparam int NP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] done_pulse = '0;
   logic          cnt_thr_we = 1'b0;
   logic [7:0]    cnt_thr_wdata = '0;
   logic          time_thr_we = 1'b0;
   logic [23:0]   time_thr_wdata = '0;
   logic          cause_clr_we = 1'b0;
   logic [7:0]    cause_clr_data = '0;
   logic          irq_en = 1'b1;
   logic [7:0]    cause_q;
   logic          irq_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   cmpl_irq_coalescer #(.NUM_PORTS(NP)) uut (
      .clk(clk), .rst_n(rst_n), .done_pulse(done_pulse),
      .cnt_thr_we(cnt_thr_we), .cnt_thr_wdata(cnt_thr_wdata),
      .time_thr_we(time_thr_we), .time_thr_wdata(time_thr_wdata),
      .cause_clr_we(cause_clr_we), .cause_clr_data(cause_clr_data),
      .irq_en(irq_en), .cause_q(cause_q), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive one cycle of inputs; returns at the negedge after the capturing edge
   task automatic step(input logic [NP-1:0] m, input logic cw, input logic [7:0] cd);
      done_pulse = m; cause_clr_we = cw; cause_clr_data = cd;
      @(negedge clk);
      done_pulse = '0; cause_clr_we = 1'b0; cause_clr_data = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step('0, 1'b0, 8'h00);
   endtask

   task automatic wr_cnt(input logic [7:0] v);
      cnt_thr_we = 1'b1; cnt_thr_wdata = v;
      @(negedge clk);
      cnt_thr_we = 1'b0;
   endtask

   task automatic wr_time(input logic [23:0] v);
      time_thr_we = 1'b1; time_thr_wdata = v;
      @(negedge clk);
      time_thr_we = 1'b0;
   endtask

   task automatic clear_bit();
      step('0, 1'b1, 8'h10);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 cause", cause_q, 8'h00);
      check("R1 irq", irq_o, 1'b0);

      // R2 thresholds are zero after reset: completions do nothing
      for (int i = 0; i < 10; i++) step(4'hF, 1'b0, 8'h00);
      idle(3);
      check("R2 off no event", cause_q, 8'h00);

      // R3 R4 R11 sweep count threshold against ports pulsing together
      wr_time(24'd1000);
      for (int c = 0; c <= 6; c++) begin
         for (int k = 1; k <= NP; k++) begin
            int ceff;
            int n;
            wr_cnt(8'(c));
            ceff = (c == 0) ? 1 : c;
            n = (ceff + k - 1) / k;
            for (int j = 1; j <= n; j++) begin
               step(NP'((1 << k) - 1), 1'b0, 8'h00);
               check((c <= 1) ? "R4 immediate" : "R3 count", cause_q[4], (j == n));
            end
            check("R10 irq", irq_o, 1'b1);
            clear_bit();
            check("R7 clear", cause_q, 8'h00);
         end
      end

      // R5 sweep time threshold, single completion
      wr_cnt(8'd200);
      for (int t = 1; t <= 8; t++) begin
         wr_time(24'(t));
         step(4'h1, 1'b0, 8'h00);
         check("R5 not yet", cause_q[4], 1'b0);
         for (int i = 1; i <= t; i++) begin
            step('0, 1'b0, 8'h00);
            check("R5 timeout", cause_q[4], (i == t));
         end
         clear_bit();
      end

      // R5 later completion does not restart the timer
      wr_time(24'd6);
      step(4'h1, 1'b0, 8'h00);
      for (int i = 1; i <= 6; i++) begin
         step((i == 2) ? 4'h2 : 4'h0, 1'b0, 8'h00);
         check("R5 no restart", cause_q[4], (i == 6));
      end
      clear_bit();

      // R6 completion on the timeout edge is absorbed
      wr_time(24'd3);
      step(4'h1, 1'b0, 8'h00);
      step('0, 1'b0, 8'h00);
      step('0, 1'b0, 8'h00);
      step(4'h4, 1'b0, 8'h00);
      check("R6 timeout fires", cause_q[4], 1'b1);
      clear_bit();
      idle(12);
      check("R6 absorbed", cause_q[4], 1'b0);

      // R6 count restarts from zero after an event
      wr_time(24'd1000);
      wr_cnt(8'd3);
      step(4'h7, 1'b0, 8'h00);
      clear_bit();
      step(4'h1, 1'b0, 8'h00);
      step(4'h1, 1'b0, 8'h00);
      check("R6 count reset", cause_q[4], 1'b0);
      step(4'h1, 1'b0, 8'h00);
      check("R6 count third", cause_q[4], 1'b1);
      clear_bit();

      // R7 clear with bit 4 clear has no effect
      wr_cnt(8'd1);
      step(4'h1, 1'b0, 8'h00);
      step('0, 1'b1, 8'hEF);
      check("R7 other bits ignored", cause_q, 8'h10);
      clear_bit();
      check("R7 cleared", cause_q, 8'h00);

      // R8 event and clear in the same cycle
      step(4'h8, 1'b0, 8'h00);
      step(4'h8, 1'b1, 8'h10);
      check("R8 set wins", cause_q, 8'h10);
      clear_bit();

      // R9 completion while cause set counts toward next event
      wr_cnt(8'd2);
      step(4'h3, 1'b0, 8'h00);
      step(4'h1, 1'b0, 8'h00);
      clear_bit();
      check("R9 cleared", cause_q[4], 1'b0);
      step(4'h2, 1'b0, 8'h00);
      check("R9 carried count", cause_q[4], 1'b1);

      // R10 enable gating
      irq_en = 1'b0;
      #1;
      check("R10 masked by enable", irq_o, 1'b0);
      irq_en = 1'b1;
      #1;
      check("R10 enabled", irq_o, 1'b1);

      // R2 switching off masks irq and drops the pending count
      wr_time(24'd0);
      check("R2 irq masked", irq_o, 1'b0);
      clear_bit();
      wr_cnt(8'd3);
      wr_time(24'd500);
      step(4'h1, 1'b0, 8'h00);
      step(4'h1, 1'b0, 8'h00);
      wr_time(24'd0);
      wr_time(24'd500);
      step(4'h1, 1'b0, 8'h00);
      step(4'h1, 1'b0, 8'h00);
      check("R2 pending dropped", cause_q[4], 1'b0);
      step(4'h1, 1'b0, 8'h00);
      check("R2 fresh batch", cause_q[4], 1'b1);
      clear_bit();

      // R11 largest time threshold: no timeout soon, count still works
      wr_time(24'hFFFFFF);
      wr_cnt(8'd255);
      step(4'h1, 1'b0, 8'h00);
      idle(100);
      check("R11 long timer", cause_q[4], 1'b0);
      for (int i = 0; i < 63; i++) step(4'hF, 1'b0, 8'h00);
      check("R11 count 253", cause_q[4], 1'b0);
      step(4'h3, 1'b0, 8'h00);
      check("R11 count 255", cause_q[4], 1'b1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule